// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block guards read data on a 64-bit bus split into eight byte lanes. Each lane carries its own parity bit, and the eight data bits plus that parity bit must hold an even number of ones. When the read-valid strobe is high at a clock edge, the block captures the data, the parity bits, the active-low byte enables and the active-low parity-enable strap. It checks every lane that is enabled, and on the next cycle it drives an active-low error flag and a mask of the lanes that failed.

The error flag is low for exactly one cycle after the sampled read. The failing-lane mask keeps its value until the next sampled read replaces it. A combinational helper also computes the eight parity bits for outgoing write data, so that each lane holds an even count of ones across its nine bits.

Top module: `bytelane_par_chk`

## Requirements
- R1: After reset, err_no is high (1) and fail_lanes_o is all zeros.
- R2: Lane n is data bits [8n+7:8n] and is covered by parity bit n. A lane fails when its eight data bits plus parity bit n hold an odd number of ones.
- R3: A lane whose byte enable bit n is high (deasserted) never fails and never sets bit n of fail_lanes_o, whatever its data or parity.
- R4: When par_en_ni is high (checking disabled) at a sampled read, err_no stays high and fail_lanes_o becomes all zeros.
- R5: Inputs are sampled only on a clock edge where rd_vld_i is 1. Edges with rd_vld_i at 0 leave err_no high and fail_lanes_o unchanged.
- R6: err_no is low for exactly the one cycle after a sampled read that has at least one failing lane, and high in every other cycle.
- R7: fail_lanes_o takes bit n = 1 for each failing lane one cycle after the sampled read, and holds that value until the next sampled read.
- R8: Any pattern of byte enables is valid, including non-contiguous ones, and each lane is judged on its own.
- R9: wr_par_o bit n is the XOR of wr_data_i[8n+7:8n], so that each lane's nine bits hold an even count of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_vld_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 64 | Read data |
| rd_par_i | input | 8 | Per-lane read parity |
| be_ni | input | 8 | Byte enables, active low |
| par_en_ni | input | 1 | Parity check enable, active low |
| wr_data_i | input | 64 | Write data |
| wr_par_o | output | 8 | Generated write parity |
| err_no | output | 1 | Parity error, active low, one cycle |
| fail_lanes_o | output | 8 | Failing lane mask |

## Verification
The block's internal state is the registered error flag and the lane mask. If that state is wrong, it shows at the ports on the first cycle after the affected sampled read. A flag that sticks or does not clear shows as err_no low for a second cycle, or low after a clean read. A mask that updates on idle edges or skips disabled lanes wrongly differs from the bench's model on the next sampled cycle, or on the first idle cycle after it.

// File: rtl/bytelane_par_pkg.sv
package bytelane_par_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned N_LANES = 8;
  localparam int unsigned DATA_W = LANE_W * N_LANES;
  typedef logic [N_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bytelane_par_gen.sv
module bytelane_par_gen
  import bytelane_par_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output lane_mask_t        par_o
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign par_o[g] = ^data_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bytelane_par_eval.sv
module bytelane_par_eval
  import bytelane_par_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  lane_mask_t        par_i,
  input  lane_mask_t        be_ni,
  input  logic              par_en_ni,
  output lane_mask_t        bad_o
);
  lane_mask_t calc;
  bytelane_par_gen u_gen (.data_i(data_i), .par_o(calc));
  // odd lane parity, gated by lane enable and global enable
  assign bad_o = (calc ^ par_i) & ~be_ni & {N_LANES{~par_en_ni}};
endmodule

// File: rtl/bytelane_par_chk.sv
module bytelane_par_chk
  import bytelane_par_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [N_LANES-1:0] rd_par_i,
  input  logic [N_LANES-1:0] be_ni,
  input  logic              par_en_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_LANES-1:0] wr_par_o,
  output logic              err_no,
  output logic [N_LANES-1:0] fail_lanes_o
);
  lane_mask_t bad;
  lane_mask_t mask_q;
  logic       err_q;

  bytelane_par_eval u_eval (
    .data_i(rd_data_i), .par_i(rd_par_i), .be_ni(be_ni),
    .par_en_ni(par_en_ni), .bad_o(bad)
  );

  bytelane_par_gen u_wgen (.data_i(wr_data_i), .par_o(wr_par_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= rd_vld_i && (|bad);
      if (rd_vld_i) mask_q <= bad;
    end
  end

  assign err_no       = ~err_q;
  assign fail_lanes_o = mask_q;
endmodule

// File: rtl/bytelane_par_chk_sva.sv
module bytelane_par_chk_sva
  import bytelane_par_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_vld_i,
  input logic [N_LANES-1:0] be_ni,
  input logic              par_en_ni,
  input logic              err_no,
  input logic [N_LANES-1:0] fail_lanes_o
);
  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_i |=> $stable(fail_lanes_o) && err_no);
  a_r3_masked_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i |=> (fail_lanes_o & $past(be_ni)) == '0);
  a_r4_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i && par_en_ni |=> err_no && fail_lanes_o == '0);
  a_r6_err_matches_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i |=> (err_no == (fail_lanes_o == '0)));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_no && !rd_vld_i |=> err_no);
endmodule

bind bytelane_par_chk bytelane_par_chk_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_vld_i(rd_vld_i), .be_ni(be_ni),
  .par_en_ni(par_en_ni), .err_no(err_no), .fail_lanes_o(fail_lanes_o)
);

// File: tb/sim_bytelane_par_chk.sv
module sim_bytelane_par_chk;
  localparam time TCLK = 10ns;
  logic clk = 0, rst_n = 0;
  logic vld = 0, pen_n = 0;
  logic [63:0] rd = '0, wd = '0;
  logic [7:0] par = '0, be_n = '1, wpar, fail;
  logic err_n;
  int checks = 0, fails = 0;
  logic [7:0] exp_mask = '0;
  logic exp_err_n = 1;

  bytelane_par_chk u0 (.clk_i(clk), .rst_ni(rst_n), .rd_vld_i(vld),
    .rd_data_i(rd), .rd_par_i(par), .be_ni(be_n), .par_en_ni(pen_n),
    .wr_data_i(wd), .wr_par_o(wpar), .err_no(err_n), .fail_lanes_o(fail));

  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [7:0] model(input logic [63:0] d, input logic [7:0] p,
                                       input logic [7:0] b, input logic en_n);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = !en_n && !b[i] && ((^d[i*8 +: 8]) ^ p[i]);
    return m;
  endfunction

  task automatic chk(input string r, input logic [7:0] am, input logic ae,
                     input logic [7:0] em, input logic ee);
    checks++;
    if (am !== em || ae !== ee) begin
      fails++;
      $display("FAIL %s mask=%h err_n=%b expected mask=%h err_n=%b", r, am, ae, em, ee);
    end
  endtask

  // drive one cycle at negedge, check outputs at next negedge
  task automatic cyc(input string r, input logic v, input logic [63:0] d,
                     input logic [7:0] p, input logic [7:0] b, input logic en);
    logic [7:0] m;
    vld = v; rd = d; par = p; be_n = b; pen_n = en;
    m = model(d, p, b, en);
    if (v) begin exp_mask = m; exp_err_n = ~|m; end else exp_err_n = 1;
    @(negedge clk);
    chk(r, fail, err_n, exp_mask, exp_err_n);
  endtask

  initial begin
    logic [63:0] d;
    void'($urandom(32'hC0FFEE));
    #(TCLK*3) @(negedge clk);
    chk("R1", fail, err_n, 8'h00, 1'b1);
    rst_n = 1;
    @(negedge clk);
    d = 64'h0123_4567_89AB_CDEF;
    cyc("R2 clean", 1, d, good_par(d), 8'h00, 0);
    cyc("R2 lane0 bad", 1, d, good_par(d) ^ 8'h01, 8'h00, 0);
    cyc("R6 pulse ends", 0, d, 8'h00, 8'h00, 0);
    cyc("R7 hold", 0, 64'h0, 8'hFF, 8'h00, 0);
    cyc("R2 lane7 bad", 1, d, good_par(d) ^ 8'h80, 8'h00, 0);
    cyc("R3 masked lanes", 1, d, ~good_par(d), 8'hFF, 0);
    cyc("R8 noncontig", 1, d, ~good_par(d), 8'b1010_0101, 0);
    cyc("R4 global off", 1, d, ~good_par(d), 8'h00, 1);
    cyc("R8 all bad", 1, d, ~good_par(d), 8'h00, 0);
    cyc("R6 back to back", 1, d, ~good_par(d), 8'h00, 0);
    cyc("R5 idle", 0, ~d, good_par(d), 8'h00, 0);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] rdd;
      rdd = {$urandom, $urandom};
      cyc("R2 R8 random", ($urandom % 4) != 0, rdd, $urandom, $urandom,
          ($urandom % 8) == 0);
    end
    for (int i = 0; i < 20; i++) begin
      wd = {$urandom, $urandom};
      #1;
      checks++;
      if (wpar !== good_par(wd)) begin
        fails++;
        $display("FAIL R9 wr_par=%h expected %h", wpar, good_par(wd));
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(TCLK*50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule